// File: doc/BRIEF.md
# Synchronous Clock Stop Controller

This block sits between a clock synthesizer and the output drivers of a system clock generator. It receives a free-running bus clock, a processor source clock and a bus source clock. It hands out three things: a group of gated processor clocks, a group of gated bus clocks, and one ungated copy of the bus clock. Two active-low stop inputs each freeze one group at logic low. An active-low power-down input forces every output low, the ungated copy included.

A stop or start request is captured on a rising edge of the free-running bus clock. It takes effect at the next falling edge of the source clock it gates. Every change of state therefore happens while that clock is low, and no high pulse is ever cut short or shortened. A single reference clock times both groups. The block relies on the source clocks being produced by the same synthesizer as the free-running bus clock, with their rising edges aligned to it. Leaving power-down brings every output up in the stopped state. Each running output then starts through the same capture-and-apply sequence.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `pwr_dn_n` is 0, every output is 0 (processor group, bus group and `bus_free_o`), whatever the stop inputs do.
- R2: A stopped group rests at logic 0 for the whole of each source period, and never holds at 1.
- R3: When `cpu_stop_n` goes from 1 (run) to 0 (stop), the request is captured at the first rising edge of `fbus_clk`. The processor high pulse that begins at that edge completes in full, and no further processor pulse appears.
- R4: When `cpu_stop_n` goes from 0 to 1, the request is captured at the first rising edge of `fbus_clk`. The enable changes at the next falling edge of `cpu_src_clk`, so the first output pulse is the next complete source high phase.
- R5: `bus_stop_n` stops and starts the bus group in the same way, with `bus_src_clk` taking the place of the processor source.
- R6: Each stop input acts on its own group only, and the other group keeps running.
- R7: `bus_free_o` ignores `bus_stop_n` and keeps running whenever power-down is inactive.
- R8: While power stays up, every high pulse on every output lasts exactly one source high time.
- R9: On release of `pwr_dn_n` all outputs start low. Running groups and `bus_free_o` resume only after a capture at a rising edge of `fbus_clk` followed by a falling edge of their own source clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fbus_clk | input | 1 | Free-running bus clock, used as the timing reference |
| cpu_src_clk | input | 1 | Processor source clock, edge-aligned to `fbus_clk` |
| bus_src_clk | input | 1 | Bus source clock, edge-aligned to `fbus_clk` |
| cpu_stop_n | input | 1 | 1 = processor group runs, 0 = stops low |
| bus_stop_n | input | 1 | 1 = bus group runs, 0 = stops low |
| pwr_dn_n | input | 1 | 0 = power-down: all outputs low, all state cleared |
| cpu_clk_o | output | NUM_CPU (2) | Gated processor clocks |
| bus_clk_o | output | NUM_BUS (5) | Gated bus clocks |
| bus_free_o | output | 1 | Ungated bus clock, low only in power-down |

## Verification
The bench builds the block with its defaults: two processor outputs, five bus outputs and one capture stage. Latency can therefore be counted to the exact source edge. Counting output pulses over a fixed window of four reference periods shows whether the pulse at the capture edge survives and whether the first restarted pulse lands one source period after capture. A pulse-width meter on every output bit catches any runt, whether from a stop, a start or a power-down exit.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  localparam int DEF_NUM_CPU     = 2;
  localparam int DEF_NUM_BUS     = 5;
  localparam int DEF_SYNC_STAGES = 1;

  // Bundle of synchronized run requests, order fixed by the top-level packing
  typedef struct packed {
    logic pwr_ok;
    logic bus_run;
    logic cpu_run;
  } run_req_t;

  localparam int RUN_REQ_W = $bits(run_req_t);

endpackage

// File: rtl/clkstop_sync.sv
// Capture chain in the reference clock domain, cleared asynchronously.
module clkstop_sync #(
  parameter int W      = 3,
  parameter int STAGES = 1
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/clkstop_gate.sv
// Falling-edge enable plus AND gate: the enable moves only while the
// source is low, so each passed high phase is whole.
module clkstop_gate #(
  parameter int N = 1
) (
  input  logic         src_clk,
  input  logic         clr_n,
  input  logic         run_req,
  output logic [N-1:0] clk_o
);

  logic en;

  always_ff @(negedge src_clk or negedge clr_n) begin
    if (!clr_n) en <= 1'b0;
    else        en <= run_req;
  end

  for (genvar g = 0; g < N; g++) begin : g_out
    assign clk_o[g] = src_clk & en;
  end

endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int NUM_CPU     = DEF_NUM_CPU,
  parameter int NUM_BUS     = DEF_NUM_BUS,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic               fbus_clk,
  input  logic               cpu_src_clk,
  input  logic               bus_src_clk,
  input  logic               cpu_stop_n,
  input  logic               bus_stop_n,
  input  logic               pwr_dn_n,
  output logic [NUM_CPU-1:0] cpu_clk_o,
  output logic [NUM_BUS-1:0] bus_clk_o,
  output logic               bus_free_o
);

  run_req_t             raw_req;
  logic [RUN_REQ_W-1:0] sync_q;
  run_req_t             req;
  logic                 cpu_req;
  logic                 bus_req;
  logic                 free_req;
  logic [0:0]           free_vec;

  // pwr_ok rises one capture after power-down is released
  assign raw_req = '{pwr_ok: 1'b1, bus_run: bus_stop_n, cpu_run: cpu_stop_n};

  clkstop_sync #(.W(RUN_REQ_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (fbus_clk),
    .clr_n (pwr_dn_n),
    .d     (raw_req),
    .q     (sync_q)
  );

  assign req      = run_req_t'(sync_q);
  assign cpu_req  = req.cpu_run & req.pwr_ok;
  assign bus_req  = req.bus_run & req.pwr_ok;
  assign free_req = req.pwr_ok;

  clkstop_gate #(.N(NUM_CPU)) u_cpu_gate (
    .src_clk (cpu_src_clk),
    .clr_n   (pwr_dn_n),
    .run_req (cpu_req),
    .clk_o   (cpu_clk_o)
  );

  clkstop_gate #(.N(NUM_BUS)) u_bus_gate (
    .src_clk (bus_src_clk),
    .clr_n   (pwr_dn_n),
    .run_req (bus_req),
    .clk_o   (bus_clk_o)
  );

  clkstop_gate #(.N(1)) u_free_gate (
    .src_clk (fbus_clk),
    .clr_n   (pwr_dn_n),
    .run_req (free_req),
    .clk_o   (free_vec)
  );

  assign bus_free_o = free_vec[0];

endmodule

// File: rtl/clkstop_ctrl_chk.sv
module clkstop_ctrl_chk #(
  parameter int NUM_CPU = 2,
  parameter int NUM_BUS = 5
) (
  input logic               fbus_clk,
  input logic               cpu_src_clk,
  input logic               bus_src_clk,
  input logic               pwr_dn_n,
  input logic               cpu_req,
  input logic               bus_req,
  input logic               free_req,
  input logic [NUM_CPU-1:0] cpu_clk_o,
  input logic [NUM_BUS-1:0] bus_clk_o,
  input logic               bus_free_o
);

  // R1: power-down holds every output low
  always @(posedge fbus_clk) begin
    if (!pwr_dn_n) begin
      a_r1_pd_all_low: assert (cpu_clk_o == '0 && bus_clk_o == '0 && !bus_free_o)
        else $error("R1: output high during power-down");
    end
  end

  // Sampled at a source falling edge: the output value seen is the one in
  // the preceding high phase, governed by the request of the previous fall.
  a_r2_cpu_stopped_low: assert property (@(negedge cpu_src_clk) disable iff (!pwr_dn_n)
    !$past(cpu_req) |-> cpu_clk_o == '0);

  a_r3_cpu_full_pulse: assert property (@(negedge cpu_src_clk) disable iff (!pwr_dn_n)
    $past(cpu_req) |-> cpu_clk_o == '1);

  a_r5_bus_stopped_low: assert property (@(negedge bus_src_clk) disable iff (!pwr_dn_n)
    !$past(bus_req) |-> bus_clk_o == '0);

  a_r5_bus_full_pulse: assert property (@(negedge bus_src_clk) disable iff (!pwr_dn_n)
    $past(bus_req) |-> bus_clk_o == '1);

  a_r7_free_runs: assert property (@(negedge fbus_clk) disable iff (!pwr_dn_n)
    $past(free_req) |-> bus_free_o);

endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(.NUM_CPU(NUM_CPU), .NUM_BUS(NUM_BUS)) u_chk (
  .fbus_clk    (fbus_clk),
  .cpu_src_clk (cpu_src_clk),
  .bus_src_clk (bus_src_clk),
  .pwr_dn_n    (pwr_dn_n),
  .cpu_req     (cpu_req),
  .bus_req     (bus_req),
  .free_req    (free_req),
  .cpu_clk_o   (cpu_clk_o),
  .bus_clk_o   (bus_clk_o),
  .bus_free_o  (bus_free_o)
);

// File: tb/sim_clkstop_ctrl.sv
`timescale 1ns/1ps

module sim_pulse_meter #(
  parameter real HIGH_NS = 4.0
) (
  input  logic sig,
  output int   rises,
  output int   nmeas,
  output int   bad
);
  realtime t0;
  bit      armed;
  initial begin rises = 0; nmeas = 0; bad = 0; armed = 0; t0 = 0; end

  always @(posedge sig) begin
    rises = rises + 1;
    t0    = $realtime;
    armed = 1;
  end

  always @(negedge sig) begin
    if (armed) begin
      nmeas = nmeas + 1;
      if (($realtime - t0) < HIGH_NS - 0.001 || ($realtime - t0) > HIGH_NS + 0.001) begin
        bad = bad + 1;
        $display("FAIL R8 %m pulse width actual=%0.3f expected=%0.3f", $realtime - t0, HIGH_NS);
      end
    end
  end
endmodule

module sim_clkstop_ctrl;
  localparam int NC = 2;
  localparam int NB = 5;

  logic fbus_clk = 1'b0;
  logic cpu_src_clk = 1'b1;
  logic bus_src_clk;
  logic cpu_stop_n = 1'b1;
  logic bus_stop_n = 1'b1;
  logic pwr_dn_n = 1'b0;
  logic [NC-1:0] cpu_clk_o;
  logic [NB-1:0] bus_clk_o;
  logic bus_free_o;

  // 125 MHz reference; processor source at twice that, rising edges aligned
  always #4 fbus_clk = ~fbus_clk;
  always #2 cpu_src_clk = ~cpu_src_clk;
  assign bus_src_clk = fbus_clk;

  clkstop_ctrl u0 (
    .fbus_clk    (fbus_clk),
    .cpu_src_clk (cpu_src_clk),
    .bus_src_clk (bus_src_clk),
    .cpu_stop_n  (cpu_stop_n),
    .bus_stop_n  (bus_stop_n),
    .pwr_dn_n    (pwr_dn_n),
    .cpu_clk_o   (cpu_clk_o),
    .bus_clk_o   (bus_clk_o),
    .bus_free_o  (bus_free_o)
  );

  int cpu_r [NC]; int cpu_m [NC]; int cpu_b [NC];
  int bus_r [NB]; int bus_m [NB]; int bus_b [NB];
  int free_r, free_m, free_b;

  for (genvar g = 0; g < NC; g++) begin : g_cm
    sim_pulse_meter #(.HIGH_NS(2.0)) m (.sig(cpu_clk_o[g]), .rises(cpu_r[g]), .nmeas(cpu_m[g]), .bad(cpu_b[g]));
  end
  for (genvar g = 0; g < NB; g++) begin : g_bm
    sim_pulse_meter #(.HIGH_NS(4.0)) m (.sig(bus_clk_o[g]), .rises(bus_r[g]), .nmeas(bus_m[g]), .bad(bus_b[g]));
  end
  sim_pulse_meter #(.HIGH_NS(4.0)) m_free (.sig(bus_free_o), .rises(free_r), .nmeas(free_m), .bad(free_b));

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int d_cpu [NC];
  int d_bus [NB];
  int d_free;
  int s_cpu [NC];
  int s_bus [NB];
  int s_free;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one time unit after a reference falling edge, clear of every clock edge
  task automatic to_slot();
    @(negedge fbus_clk);
    #1;
  endtask

  task automatic snap();
    for (int i = 0; i < NC; i++) s_cpu[i] = cpu_r[i];
    for (int i = 0; i < NB; i++) s_bus[i] = bus_r[i];
    s_free = free_r;
  endtask

  // four reference periods after the snapshot
  task automatic close_window();
    repeat (4) @(negedge fbus_clk);
    #1;
    for (int i = 0; i < NC; i++) d_cpu[i] = cpu_r[i] - s_cpu[i];
    for (int i = 0; i < NB; i++) d_bus[i] = bus_r[i] - s_bus[i];
    d_free = free_r - s_free;
  endtask

  task automatic expect_counts(input string req, input int ec, input int eb, input int ef);
    for (int i = 0; i < NC; i++) chk(req, $sformatf("cpu_clk_o[%0d] pulses", i), d_cpu[i], ec);
    for (int i = 0; i < NB; i++) chk(req, $sformatf("bus_clk_o[%0d] pulses", i), d_bus[i], eb);
    chk(req, "bus_free_o pulses", d_free, ef);
  endtask

  task automatic t_reset_state();
    #3;
    chk("R1", "cpu_clk_o at reset", int'(cpu_clk_o), 0);
    chk("R1", "bus_clk_o at reset", int'(bus_clk_o), 0);
    chk("R1", "bus_free_o at reset", int'(bus_free_o), 0);
    to_slot();
    snap();
    cpu_stop_n = 1'b0; bus_stop_n = 1'b0;
    #9 cpu_stop_n = 1'b1; bus_stop_n = 1'b1;
    close_window();
    expect_counts("R1", 0, 0, 0);
  endtask

  task automatic t_pd_exit_all_run();
    to_slot();
    snap();
    pwr_dn_n = 1'b1;
    close_window();
    expect_counts("R9", 7, 3, 3);
    snap();
    close_window();
    expect_counts("R6", 8, 4, 4);
  endtask

  task automatic t_cpu_stop();
    to_slot();
    snap();
    cpu_stop_n = 1'b0;
    close_window();
    expect_counts("R3", 1, 4, 4);
    snap();
    close_window();
    expect_counts("R6", 0, 4, 4);
    @(posedge cpu_src_clk); #0.5;
    chk("R2", "cpu_clk_o while stopped, source high", int'(cpu_clk_o), 0);
  endtask

  task automatic t_cpu_start();
    to_slot();
    snap();
    cpu_stop_n = 1'b1;
    close_window();
    expect_counts("R4", 7, 4, 4);
  endtask

  task automatic t_bus_stop();
    to_slot();
    snap();
    bus_stop_n = 1'b0;
    close_window();
    expect_counts("R5", 8, 1, 4);
    snap();
    close_window();
    expect_counts("R7", 8, 0, 4);
    @(posedge bus_src_clk); #0.5;
    chk("R2", "bus_clk_o while stopped, source high", int'(bus_clk_o), 0);
    chk("R7", "bus_free_o while bus stopped, source high", int'(bus_free_o), 1);
  endtask

  task automatic t_bus_start();
    to_slot();
    snap();
    bus_stop_n = 1'b1;
    close_window();
    expect_counts("R5", 8, 3, 4);
  endtask

  task automatic t_powerdown();
    to_slot();
    #2;  // both sources low here
    pwr_dn_n = 1'b0;
    #0.5;
    chk("R1", "outputs right after power-down", int'({cpu_clk_o, bus_clk_o, bus_free_o}), 0);
    snap();
    cpu_stop_n = 1'b0;
    #5 bus_stop_n = 1'b0;
    #5 cpu_stop_n = 1'b1; bus_stop_n = 1'b1;
    close_window();
    expect_counts("R1", 0, 0, 0);
  endtask

  task automatic t_pd_exit_cpu_held();
    cpu_stop_n = 1'b0;
    to_slot();
    snap();
    pwr_dn_n = 1'b1;
    close_window();
    expect_counts("R9", 0, 3, 3);
  endtask

  task automatic t_widths();
    int tb_bad = 0;
    int tb_meas = 0;
    for (int i = 0; i < NC; i++) begin tb_bad += cpu_b[i]; tb_meas += cpu_m[i]; end
    for (int i = 0; i < NB; i++) begin tb_bad += bus_b[i]; tb_meas += bus_m[i]; end
    tb_bad += free_b; tb_meas += free_m;
    chk("R8", "runt pulses seen", tb_bad, 0);
    chk("R8", "pulses measured (nonzero)", int'(tb_meas > 100), 1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    t_reset_state();
    t_pd_exit_all_run();
    t_cpu_stop();
    t_cpu_start();
    t_bus_stop();
    t_bus_start();
    t_powerdown();
    t_pd_exit_cpu_held();
    t_widths();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule